// File: doc/BRIEF.md
# Switched-Capacitor Sampling Phase Sequencer

This block drives the switches of a flying-capacitor sampling stage from a single digital clock. When a run is started it first calibrates the stage and then holds the result. In calibration the capacitors are cleared and the amplifier is placed in unity gain. After that it loops through sample and hold frames until start is withdrawn. A new start always begins with calibration again. Each hold is entered through a charge-cancelling pre-hold. The switch that was closed opens first. A parasitic discharge path then closes while the feedback-reset switch is still closed. Once the discharge ends, both of those switches open, and only then does the charge-transfer switch close.

Every change between the mutually exclusive switches is break-before-make. The idle window between an opening and the next closing lasts a programmable number of clock cycles. A half-rate reference is divided from the clock and brought out as a sixth phase. Runs are launched only in alignment with it. A hold-valid strobe tells a downstream converter when the held sample may be taken. It is high during the transfer of a sampling frame, except for that transfer's first cycle, which is left for settling.

Top module: `scps_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every output is low: all five switch phases, the reference and hold-valid.
- R2: The reference output `ph_ref_o` toggles on every clock after reset. A start is accepted from idle only at a clock edge where the reference is high, so calibration always begins in a cycle with the reference low. A start held for a single cycle while the reference is low is ignored.
- R3: An accepted start closes the calibration switch together with the feedback-reset switch for CAL_CYC cycles.
- R4: At most one of calibrate, sample, discharge and transfer is high in any cycle. Between the opening of one of them and the closing of the next there are exactly D cycles in which none of them is high, where D is the latched dead time.
- R5: Pre-hold order. The calibrate or sample switch opens. For D cycles only feedback-reset stays high. Discharge and feedback-reset are then high together for DIS_CYC cycles and both open in the same cycle. After D idle cycles, transfer is high for HOLD_CYC cycles.
- R6: After the transfer of a frame and D idle cycles, if start is high, a sampling frame begins. In it, sample and feedback-reset are high for SMP_CYC cycles and calibration is not repeated.
- R7: Hold-valid is high only during the transfer of a sampling frame, in every transfer cycle except the first (HOLD_CYC-1 cycles). It is never high in the hold that follows calibration.
- R8: If start is low at the end of the idle window after a transfer, the sequencer returns to idle with all switch phases low. A later accepted start runs calibration again.
- R9: The dead-time input is latched when a start is accepted and is used for the whole run. Changes during a run have no effect, and a value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request; level held for continuous sampling |
| dead_i | input | DT_W | Dead time in clock cycles (0 acts as 1) |
| ph_cal_o | output | 1 | Calibration switch (capacitor clear, unity gain) |
| ph_smp_o | output | 1 | Sampling switch |
| ph_dis_o | output | 1 | Parasitic discharge switch |
| ph_fbr_o | output | 1 | Feedback-reset switch |
| ph_xfr_o | output | 1 | Charge-transfer switch |
| ph_ref_o | output | 1 | Half-rate reference phase |
| hold_valid_o | output | 1 | Held output may be sampled |

## Verification
The bench uses CAL_CYC=6, SMP_CYC=5, DIS_CYC=3 and HOLD_CYC=4 with a 4-bit dead time. Short frames let full calibration and several sampling frames fit in a few hundred cycles. With these settings the bench covers dead times of 0, 2, 3 and 15, a dead-time change in the middle of a run, and stopping after the calibration hold. It also covers a one-cycle start that lands on the wrong reference phase and a one-cycle start that lands on the right one.

// File: rtl/scps_pkg.sv
package scps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TRACK  = 3'd1,
        ST_PRE    = 3'd2,
        ST_DIS    = 3'd3,
        ST_GAP    = 3'd4,
        ST_SETTLE = 3'd5,
        ST_XFER   = 3'd6,
        ST_POST   = 3'd7
    } seq_st_e;

    typedef struct packed {
        logic cal;
        logic smp;
        logic dis;
        logic fbr;
        logic xfr;
        logic hv;
    } phase_t;

endpackage

// File: rtl/scps_refdiv.sv
module scps_refdiv (
    input  logic clk,
    input  logic rst_n,
    output logic ref_o
);
    logic ref_d, ref_q;

    always_comb begin
        ref_d = ~ref_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_d;
    end

    assign ref_o = ref_q;
endmodule

// File: rtl/scps_timer.sv
module scps_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scps_decode.sv
module scps_decode
    import scps_pkg::*;
(
    input  seq_st_e st_i,
    input  logic    cal_mode_i,
    output phase_t  ph_o
);
    always_comb begin
        ph_o     = '0;
        ph_o.cal = (st_i == ST_TRACK) &&  cal_mode_i;
        ph_o.smp = (st_i == ST_TRACK) && !cal_mode_i;
        ph_o.fbr = (st_i == ST_TRACK) || (st_i == ST_PRE) || (st_i == ST_DIS);
        ph_o.dis = (st_i == ST_DIS);
        ph_o.xfr = (st_i == ST_SETTLE) || (st_i == ST_XFER);
        ph_o.hv  = (st_i == ST_XFER) && !cal_mode_i;
    end
endmodule

// File: rtl/scps_seq.sv
module scps_seq
    import scps_pkg::*;
#(
    parameter int DT_W     = 4,
    parameter int CAL_CYC  = 32,
    parameter int SMP_CYC  = 16,
    parameter int DIS_CYC  = 4,
    parameter int HOLD_CYC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            ph_cal_o,
    output logic            ph_smp_o,
    output logic            ph_dis_o,
    output logic            ph_fbr_o,
    output logic            ph_xfr_o,
    output logic            ph_ref_o,
    output logic            hold_valid_o
);
    localparam int DT_MAX  = (1 << DT_W) - 1;
    localparam int M1      = (CAL_CYC > SMP_CYC) ? CAL_CYC : SMP_CYC;
    localparam int M2      = (DIS_CYC > HOLD_CYC) ? DIS_CYC : HOLD_CYC;
    localparam int M3      = (M1 > M2) ? M1 : M2;
    localparam int LEN_MAX = (M3 > DT_MAX) ? M3 : DT_MAX;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    typedef struct packed {
        seq_st_e         st;
        logic            cal_mode;
        logic [DT_W-1:0] dead;
    } seq_t;

    seq_t             s_d, s_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             t_zero;
    logic             ref_q;
    phase_t           ph;

    scps_refdiv u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_o (ref_q)
    );

    scps_timer #(.W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .val_i  (ld_val),
        .zero_o (t_zero)
    );

    always_comb begin
        s_d    = s_q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i && ref_q) begin
                    s_d.st       = ST_TRACK;
                    s_d.cal_mode = 1'b1;
                    s_d.dead     = (dead_i == '0) ? DT_W'(1) : dead_i;
                    ld           = 1'b1;
                    ld_val       = CNT_W'(CAL_CYC - 1);
                end
            end
            ST_TRACK: if (t_zero) begin
                s_d.st = ST_PRE;
                ld     = 1'b1;
                ld_val = CNT_W'(s_q.dead) - CNT_W'(1);
            end
            ST_PRE: if (t_zero) begin
                s_d.st = ST_DIS;
                ld     = 1'b1;
                ld_val = CNT_W'(DIS_CYC - 1);
            end
            ST_DIS: if (t_zero) begin
                s_d.st = ST_GAP;
                ld     = 1'b1;
                ld_val = CNT_W'(s_q.dead) - CNT_W'(1);
            end
            ST_GAP: if (t_zero) begin
                s_d.st = ST_SETTLE;
                ld     = 1'b1;
                ld_val = '0;
            end
            ST_SETTLE: if (t_zero) begin
                s_d.st = ST_XFER;
                ld     = 1'b1;
                ld_val = CNT_W'(HOLD_CYC - 2);
            end
            ST_XFER: if (t_zero) begin
                s_d.st = ST_POST;
                ld     = 1'b1;
                ld_val = CNT_W'(s_q.dead) - CNT_W'(1);
            end
            ST_POST: if (t_zero) begin
                if (start_i) begin
                    s_d.st       = ST_TRACK;
                    s_d.cal_mode = 1'b0;
                    ld           = 1'b1;
                    ld_val       = CNT_W'(SMP_CYC - 1);
                end else begin
                    s_d.st       = ST_IDLE;
                    s_d.cal_mode = 1'b0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= ST_IDLE;
            s_q.cal_mode <= 1'b0;
            s_q.dead     <= DT_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    scps_decode u_dec (
        .st_i       (s_q.st),
        .cal_mode_i (s_q.cal_mode),
        .ph_o       (ph)
    );

    assign ph_cal_o     = ph.cal;
    assign ph_smp_o     = ph.smp;
    assign ph_dis_o     = ph.dis;
    assign ph_fbr_o     = ph.fbr;
    assign ph_xfr_o     = ph.xfr;
    assign hold_valid_o = ph.hv;
    assign ph_ref_o     = ref_q;
endmodule

// File: rtl/scps_seq_chk.sv
module scps_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cal,
    input logic smp,
    input logic dis,
    input logic fbr,
    input logic xfr,
    input logic refp,
    input logic hv
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !(cal || smp || dis || fbr || xfr || refp || hv));

    // R2
    ref_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (refp != $past(refp)));

    // R2
    cal_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal) |-> !refp);

    // R3
    cal_with_fbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal) |-> fbr);

    // R4
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cal, smp, dis, xfr}) <= 1);

    // R4
    break_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cal) || $rose(smp) || $rose(dis) || $rose(xfr))
            |-> !($past(cal) || $past(smp) || $past(dis) || $past(xfr)));

    // R5
    fbr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fbr) |-> $past(dis));

    // R5
    xfr_after_fbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfr) |-> !$past(fbr));

    // R6
    smp_with_fbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp) |-> fbr);

    // R7
    hv_in_xfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hv |-> (xfr && $past(xfr)));
endmodule

bind scps_seq scps_seq_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cal  (ph_cal_o),
    .smp  (ph_smp_o),
    .dis  (ph_dis_o),
    .fbr  (ph_fbr_o),
    .xfr  (ph_xfr_o),
    .refp (ph_ref_o),
    .hv   (hold_valid_o)
);

// File: tb/scps_seq_tb.sv
module scps_seq_tb;
    localparam int DTW   = 4;
    localparam int CALC  = 6;
    localparam int SMPC  = 5;
    localparam int DISC  = 3;
    localparam int HOLDC = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [DTW-1:0] dt = '0;
    logic cal, smp, dis, fbr, xfr, refp, hv;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    scps_seq #(
        .DT_W(DTW), .CAL_CYC(CALC), .SMP_CYC(SMPC),
        .DIS_CYC(DISC), .HOLD_CYC(HOLDC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dead_i(dt),
        .ph_cal_o(cal), .ph_smp_o(smp), .ph_dis_o(dis), .ph_fbr_o(fbr),
        .ph_xfr_o(xfr), .ph_ref_o(refp), .hold_valid_o(hv)
    );

    // reference model: expected vector {cal,smp,dis,fbr,xfr,hv}
    logic [5:0] q[$];
    logic [5:0] exp_ph = '0;
    logic       exp_ref = 1'b0;
    logic       old_ref;
    bit         running = 0;
    int         dm = 1;

    task automatic push_n(input logic [5:0] v, input int n);
        for (int i = 0; i < n; i++) q.push_back(v);
    endtask

    task automatic push_frame(input bit is_cal, input int d);
        push_n(is_cal ? 6'b100100 : 6'b010100, is_cal ? CALC : SMPC);
        push_n(6'b000100, d);
        push_n(6'b001100, DISC);
        push_n(6'b000000, d);
        if (is_cal) push_n(6'b000010, HOLDC);
        else begin
            push_n(6'b000010, 1);
            push_n(6'b000011, HOLDC - 1);
        end
        push_n(6'b000000, d);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            running = 0;
            exp_ph  = '0;
            exp_ref = 1'b0;
        end else begin
            old_ref = exp_ref;
            exp_ref = ~exp_ref;
            if (q.size() == 0) begin
                if (running) begin
                    if (start) push_frame(0, dm);
                    else running = 0;
                end else if (start && old_ref) begin
                    dm = (dt == '0) ? 1 : int'(dt);
                    running = 1;
                    push_frame(1, dm);
                end
            end
            exp_ph = (q.size() > 0) ? q.pop_front() : 6'b0;
        end
    end

    function automatic string tag_of(input logic [6:0] diff);
        if (diff[6]) return "R3";
        if (diff[5]) return "R6";
        if (diff[4] || diff[3] || diff[2]) return "R5";
        if (diff[1]) return "R7";
        return "R2";
    endfunction

    // monitors sampled away from the active edge
    logic [6:0] act, expv;
    int  gapc = 0, last_gap = -1, hv_cnt = 0, cal_rises = 0;
    logic prev_xfr = 1'b0, prev_cal = 1'b0;
    string scen = "R1";

    always @(negedge clk) begin
        if (rst_n) begin
            act  = {cal, smp, dis, fbr, xfr, hv, refp};
            expv = {exp_ph, exp_ref};
            checks++;
            if (act !== expv) begin
                errors++;
                $display("FAIL %s (%s) cycle compare: actual=%b expected=%b",
                         tag_of(act ^ expv), scen, act, expv);
            end
            // R4 mutual exclusion
            checks++;
            if ((int'(cal) + int'(smp) + int'(dis) + int'(xfr)) > 1) begin
                errors++;
                $display("FAIL R4 exclusive phases overlap: actual=%b expected=at most one", {cal, smp, dis, xfr});
            end
            if (!(cal || smp || dis || xfr)) gapc++;
            else begin
                if (xfr && !prev_xfr) last_gap = gapc;
                gapc = 0;
            end
            if (hv) hv_cnt++;
            if (cal && !prev_cal) cal_rises++;
            prev_xfr = xfr;
            prev_cal = cal;
        end
    end

    task automatic check(input string tag, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual=timeout expected=run complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int hv0, cr0;
    initial begin
        // R1 reset state
        cyc(3);
        check("R1", int'({cal, smp, dis, fbr, xfr, refp, hv}), 0, "outputs in reset");
        rst_n = 1'b1;
        cyc(1);
        check("R1", int'({cal, smp, dis, fbr, xfr, hv}), 0, "phases after release");

        // R2: one-cycle start on the wrong reference phase is ignored
        scen = "R2";
        while (refp != 1'b0) cyc(1);
        start = 1'b1; cyc(1); start = 1'b0;
        cyc(8);
        check("R2", cal_rises, 0, "start with reference low ignored");
        check("R2", int'({cal, smp, dis, fbr, xfr, hv}), 0, "still idle");

        // continuous run, dead time 2, then change mid-run (R9)
        scen = "R6";
        dt = 4'd2; start = 1'b1;
        cyc(100);
        check("R4", last_gap, 2, "idle window before transfer");
        check("R3", cal_rises, 1, "calibration once per run");
        scen = "R9";
        dt = 4'd7;
        cyc(100);
        check("R9", last_gap, 2, "mid-run dead-time change ignored");
        check("R6", cal_rises, 1, "no recalibration while running");
        check("R7", int'(hv_cnt > 0), 1, "hold-valid seen in sampling frames");
        scen = "R8";
        start = 1'b0;
        cyc(120);
        check("R8", int'({cal, smp, dis, fbr, xfr, hv}), 0, "idle after stop");

        // dead time 0 acts as 1, new start recalibrates
        scen = "R9";
        dt = 4'd0; start = 1'b1;
        cyc(80);
        check("R9", last_gap, 1, "zero dead time acts as one");
        check("R8", cal_rises, 2, "new start recalibrates");
        start = 1'b0;
        cyc(80);

        // largest dead time
        scen = "R4";
        dt = 4'd15; start = 1'b1;
        cyc(150);
        check("R4", last_gap, 15, "dead time fifteen");
        start = 1'b0;
        cyc(150);
        check("R8", int'({cal, smp, dis, fbr, xfr, hv}), 0, "idle after long run");

        // single aligned start pulse: calibration hold only, no hold-valid
        scen = "R7";
        hv0 = hv_cnt; cr0 = cal_rises;
        dt = 4'd3;
        while (refp != 1'b1) cyc(1);
        start = 1'b1; cyc(1); start = 1'b0;
        cyc(60);
        check("R2", cal_rises - cr0, 1, "aligned start accepted");
        check("R7", hv_cnt - hv0, 0, "no hold-valid in calibration hold");
        check("R8", int'({cal, smp, dis, fbr, xfr, hv}), 0, "idle after calibration only");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule